// File: doc/BRIEF.md
# I2C Register Target

This block is a bus target for a two-wire serial bus. It watches an SCL/SDA pair that is oversampled on a much faster system clock, decodes START, repeated START and STOP, and answers to one 7-bit address. The upper six address bits are a parameter. The lowest bit comes from a strap pin. Through a simple synchronous port to a register bank that sits beside it, a host on the bus can set a register pointer, write a run of registers and read a run of registers back.

A write transaction carries the address with a 0 direction bit, then one pointer byte, then any number of data bytes. Each data byte goes to the register the pointer selects, and the pointer then steps by one. A data byte is acknowledged only when the bank reports that the selected register exists. A read transaction sets the pointer in the same way, then issues a repeated START with the address and a 1 direction bit. The target then returns bytes from consecutive registers until the host answers a byte with NACK. SDA is only ever pulled low or left released.

Top module: `i2c_reg_target`

## Requirements
- R1: While and just after `rstN` is low (synchronous reset), `sdaDriveLow`, `regWrEn` and `regRdEn` are 0 and `regAddr` is 0.
- R2: The own address is {`ADDR_UPPER`, a0}, with default `ADDR_UPPER` = 6'b101100, giving 0x58 when a0 = 0. a0 is taken from `addrSel` during reset. A matching address byte (0xB0 for write, 0xB1 for read when a0 = 0) is acknowledged by holding SDA low through the ninth SCL pulse.
- R3: Any other address byte is not acknowledged. The bytes that follow it are then ignored: no acknowledge and no register write until the next START or STOP.
- R4: The general-call byte 0x00 reloads a0 from `addrSel`. The target does not acknowledge it. Afterwards only the address built from the new a0 is answered.
- R5: In a write transaction the byte after the address is acknowledged and loaded into the pointer. Each later byte is presented on `regWrData` at `regAddr` = pointer with a one-cycle `regWrEn`.
- R6: A data byte is acknowledged and written only if `regValid` is high for the current pointer. Otherwise it is NACKed and not written. In both cases the pointer then increments by one.
- R7: After a repeated START with the read address, the target shifts out bytes MSB first from consecutive registers, starting at the pointer. Each byte is fetched with a one-cycle `regRdEn` and taken from `regRdData` on the following clock.
- R8: A host ACK on the ninth clock makes the target send the next byte. A host NACK ends the read: SDA stays released and no further fetch happens until the next START or STOP. The pointer is left one past the last byte sent.
- R9: A STOP, or a START in the middle of a byte, aborts the transfer without a write, and the next address byte is decoded normally. The pointer keeps its value, so a read that starts with no pointer byte continues from it.
- R10: `sdaDriveLow` changes only while SCL is low.
- R11: `regWrEn` and `regRdEn` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Synchronous active-low reset; also strobes in the strap pin |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| addrSel | input | 1 | Strap pin giving the lowest address bit |
| sdaDriveLow | output | 1 | 1 pulls SDA low, 0 releases it |
| regAddr | output | PTR_W | Register pointer presented to the bank |
| regWrEn | output | 1 | One-cycle write strobe |
| regWrData | output | 8 | Byte to write |
| regRdEn | output | 1 | One-cycle read strobe; data is expected on the next clock |
| regRdData | input | 8 | Byte returned by the bank |
| regValid | input | 1 | The bank holds a register at `regAddr` |

## Verification
Single-byte writes are driven from a table of pointers. Some pointers fall inside the bank and some outside, and this separates acknowledged from refused data bytes and shows that the pointer moves either way. A burst that runs past the last supported register and a multi-byte read ended by a host NACK set consecutive addressing apart from the cases at the ends of a run. Foreign addresses, the general call with a changed strap, a reset with the strap restored, an abort by a START in the middle of a byte, and a read that starts with no pointer byte show that address matching, the strap latch and pointer retention each behave on their own.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_ACK,
    ST_HACK,
    ST_SKIP
  } busState_t;

  typedef struct packed {
    logic bitClr;
    logic bitInc;
    logic shiftIn;
    logic txNext;
    logic loadPtr;
    logic incPtr;
    logic relatchA0;
    logic rdFetch;
    logic wrData;
    logic driveAck;
    logic driveBit;
    logic relBus;
  } dpStrobe_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLevel,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclPipe;
  logic [LAST:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;
  logic sclNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[LAST-1:0], sclIn};
      sdaPipe <= {sdaPipe[LAST-1:0], sdaIn};
      sclPrev <= sclPipe[LAST];
      sdaPrev <= sdaPipe[LAST];
    end
  end

  assign sclNow   = sclPipe[LAST];
  assign sdaLevel = sdaPipe[LAST];
  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startEv  = sclNow & sclPrev & sdaPrev & ~sdaLevel;
  assign stopEv   = sclNow & sclPrev & ~sdaPrev & sdaLevel;
endmodule

// File: rtl/i2c_tgt_datapath.sv
module i2c_tgt_datapath
  import i2c_tgt_pkg::*;
#(
  parameter logic [5:0] ADDR_UPPER = 6'b101100,
  parameter int         PTR_W      = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           stb,
  input  logic                sdaLevel,
  input  logic                addrSel,
  input  logic [BYTE_W-1:0]   regRdData,
  output logic [CNT_W-1:0]    bitCnt,
  output logic                addrMatch,
  output logic                genCall,
  output logic                rwBit,
  output logic                sdaDriveLow,
  output logic [PTR_W-1:0]    regAddr,
  output logic [BYTE_W-1:0]   regWrData
);
  logic [BYTE_W-1:0] shiftReg;
  logic [PTR_W-1:0]  ptr;
  logic              a0;
  logic              rdPending;
  logic              sdaLow;

  // strap bit: captured while in reset and on a general call
  always_ff @(posedge clk) begin
    if (!rstN || stb.relatchA0) a0 <= addrSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      ptr       <= '0;
      bitCnt    <= '0;
      rdPending <= 1'b0;
      sdaLow    <= 1'b0;
    end else begin
      rdPending <= stb.rdFetch;

      if (rdPending)        shiftReg <= regRdData;
      else if (stb.shiftIn) shiftReg <= {shiftReg[BYTE_W-2:0], sdaLevel};
      else if (stb.txNext)  shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};

      if (stb.loadPtr)     ptr <= shiftReg[PTR_W-1:0];
      else if (stb.incPtr) ptr <= ptr + 1'b1;

      if (stb.bitClr)      bitCnt <= '0;
      else if (stb.bitInc) bitCnt <= bitCnt + 1'b1;

      if (stb.relBus)        sdaLow <= 1'b0;
      else if (stb.driveAck) sdaLow <= 1'b1;
      else if (stb.driveBit) sdaLow <= ~shiftReg[BYTE_W-1];
      else if (stb.txNext)   sdaLow <= ~shiftReg[BYTE_W-2];
    end
  end

  assign addrMatch   = (shiftReg[BYTE_W-1:1] == {ADDR_UPPER, a0});
  assign genCall     = (shiftReg == '0);
  assign rwBit       = shiftReg[0];
  assign sdaDriveLow = sdaLow;
  assign regAddr     = ptr;
  assign regWrData   = shiftReg;
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             startEv,
  input  logic             stopEv,
  input  logic             sdaLevel,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             addrMatch,
  input  logic             genCall,
  input  logic             rwBit,
  input  logic             regValid,
  output dpStrobe_t        stb
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  busState_t state, stateD;
  busState_t nextState, nextD;
  logic      hostAck, hostAckD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      nextState <= ST_IDLE;
      hostAck   <= 1'b0;
    end else begin
      state     <= stateD;
      nextState <= nextD;
      hostAck   <= hostAckD;
    end
  end

  always_comb begin
    stb      = '0;
    stateD   = state;
    nextD    = nextState;
    hostAckD = hostAck;
    if (stopEv) begin
      stateD     = ST_IDLE;
      stb.relBus = 1'b1;
      stb.bitClr = 1'b1;
    end else if (startEv) begin
      stateD     = ST_ADDR;
      stb.relBus = 1'b1;
      stb.bitClr = 1'b1;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (sclRise && bitCnt < LAST_BIT) begin
            stb.shiftIn = 1'b1;
            stb.bitInc  = 1'b1;
          end else if (sclFall && bitCnt == LAST_BIT) begin
            stb.bitClr = 1'b1;
            stateD     = ST_ACK;
            if (state == ST_ADDR) begin
              if (genCall) begin
                stb.relatchA0 = 1'b1;
                stateD        = ST_SKIP;
              end else if (addrMatch) begin
                stb.driveAck = 1'b1;
                if (rwBit) begin
                  stb.rdFetch = 1'b1;
                  stb.incPtr  = 1'b1;
                  nextD       = ST_RDATA;
                end else begin
                  nextD = ST_PTR;
                end
              end else begin
                stateD = ST_SKIP;
              end
            end else if (state == ST_PTR) begin
              stb.loadPtr  = 1'b1;
              stb.driveAck = 1'b1;
              nextD        = ST_WDATA;
            end else begin
              stb.incPtr = 1'b1;
              nextD      = ST_WDATA;
              if (regValid) begin
                stb.wrData   = 1'b1;
                stb.driveAck = 1'b1;
              end
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            stateD = nextState;
            if (nextState == ST_RDATA) stb.driveBit = 1'b1;
            else                       stb.relBus   = 1'b1;
          end
        end
        ST_RDATA: begin
          if (sclRise) begin
            stb.bitInc = 1'b1;
          end else if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              stb.relBus = 1'b1;
              stb.bitClr = 1'b1;
              stateD     = ST_HACK;
            end else if (bitCnt != '0) begin
              stb.txNext = 1'b1;
            end
          end
        end
        ST_HACK: begin
          if (sclRise) begin
            hostAckD = ~sdaLevel;
            if (!sdaLevel) begin
              stb.rdFetch = 1'b1;
              stb.incPtr  = 1'b1;
            end
          end else if (sclFall) begin
            if (hostAck) begin
              stb.driveBit = 1'b1;
              stateD       = ST_RDATA;
            end else begin
              stateD = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [5:0] ADDR_UPPER  = 6'b101100,
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             addrSel,
  output logic             sdaDriveLow,
  output logic [PTR_W-1:0] regAddr,
  output logic             regWrEn,
  output logic [7:0]       regWrData,
  output logic             regRdEn,
  input  logic [7:0]       regRdData,
  input  logic             regValid
);
  logic             sdaLevel, sclRise, sclFall, startEv, stopEv;
  logic [CNT_W-1:0] bitCnt;
  logic             addrMatch, genCall, rwBit;
  dpStrobe_t        stb;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaLevel(sdaLevel), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  i2c_tgt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .sdaLevel(sdaLevel),
    .bitCnt(bitCnt), .addrMatch(addrMatch), .genCall(genCall),
    .rwBit(rwBit), .regValid(regValid), .stb(stb)
  );

  i2c_tgt_datapath #(.ADDR_UPPER(ADDR_UPPER), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaLevel(sdaLevel),
    .addrSel(addrSel), .regRdData(regRdData), .bitCnt(bitCnt),
    .addrMatch(addrMatch), .genCall(genCall), .rwBit(rwBit),
    .sdaDriveLow(sdaDriveLow), .regAddr(regAddr), .regWrData(regWrData)
  );

  assign regWrEn = stb.wrData;
  assign regRdEn = stb.rdFetch;
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclIn,
  input logic             sdaDriveLow,
  input logic [PTR_W-1:0] regAddr,
  input logic             regWrEn,
  input logic             regRdEn,
  input logic             regValid
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (!sdaDriveLow && regAddr == '0 && !regWrEn && !regRdEn));

  // R5
  write_ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regAddr == $past(regAddr) + 1'b1);

  // R6
  write_only_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> regValid);

  // R7
  read_ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> regAddr == $past(regAddr) + 1'b1);

  // R10
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaDriveLow));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regRdEn));
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDriveLow(sdaDriveLow),
  .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn), .regValid(regValid)
);

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;
  localparam int H = 16;
  localparam int NREG_OK = 12;
  localparam logic [7:0] AW0 = 8'hB0, AR0 = 8'hB1, AW1 = 8'hB2, AR1 = 8'hB3;
  // {pointer, data, expected data ack}
  localparam logic [16:0] WR_VEC [7] = '{
    {8'd0,   8'h11, 1'b1}, {8'd5,  8'hA5, 1'b1}, {8'd11, 8'h3C, 1'b1},
    {8'd12,  8'h77, 1'b0}, {8'd200, 8'h99, 1'b0}, {8'd3, 8'h00, 1'b1},
    {8'd7,   8'hFF, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLine = 1'b1;
  logic hostSda = 1'b1;
  logic addrSel = 1'b0;
  logic sdaDriveLow, regWrEn, regRdEn, regValid;
  logic [7:0] regAddr, regWrData, regRdData, rdQ;
  logic sdaLine;
  logic [7:0] mem [256];
  logic [7:0] expMem [256];
  int wrCount = 0, rdCount = 0, r10Viol = 0, r11Viol = 0;
  int passCnt = 0, failCnt = 0;
  logic sclPrevTb = 1'b1, drvPrevTb = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  assign sdaLine   = hostSda & ~sdaDriveLow;
  assign regValid  = (regAddr < 8'(NREG_OK));
  assign regRdData = rdQ;

  i2c_reg_target u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .addrSel(addrSel), .sdaDriveLow(sdaDriveLow), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdData(regRdData), .regValid(regValid)
  );

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 8'(i * 7 + 3);
      expMem[i] = 8'(i * 7 + 3);
    end
    rdQ = 8'h00;
  end

  // bank model with one-cycle read latency, plus port monitors
  always @(posedge clk) begin
    if (regWrEn) begin
      mem[regAddr] <= regWrData;
      wrCount <= wrCount + 1;
    end
    if (regRdEn) begin
      rdQ <= mem[regAddr];
      rdCount <= rdCount + 1;
    end
    if (rstN && sclLine && sclPrevTb && (sdaDriveLow != drvPrevTb)) r10Viol <= r10Viol + 1;
    if (regWrEn && regRdEn) r11Viol <= r11Viol + 1;
    sclPrevTb <= sclLine;
    drvPrevTb <= sdaDriveLow;
  end

  task automatic chk(input string tag, input int act, input int exp);
    if (act == exp) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    hostSda = 1'b1; waitCyc(H);
    sclLine = 1'b1; waitCyc(H);
    hostSda = 1'b0; waitCyc(H);
    sclLine = 1'b0; waitCyc(H);
  endtask

  task automatic busStop();
    hostSda = 1'b0; waitCyc(H);
    sclLine = 1'b1; waitCyc(H);
    hostSda = 1'b1; waitCyc(H);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      hostSda = b[i]; waitCyc(H);
      sclLine = 1'b1; waitCyc(H);
      sclLine = 1'b0; waitCyc(2);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output int acked);
    sendBits(b, 8);
    hostSda = 1'b1; waitCyc(H);
    sclLine = 1'b1; waitCyc(H / 2);
    acked = sdaLine ? 0 : 1;
    waitCyc(H / 2);
    sclLine = 1'b0; waitCyc(2);
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    hostSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitCyc(H);
      sclLine = 1'b1; waitCyc(H / 2);
      b[i] = sdaLine;
      waitCyc(H / 2);
      sclLine = 1'b0; waitCyc(2);
    end
    hostSda = giveAck ? 1'b0 : 1'b1; waitCyc(H);
    sclLine = 1'b1; waitCyc(H);
    sclLine = 1'b0; waitCyc(2);
    hostSda = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
      $finish;
    end
  end

  initial begin
    int ack, w0, rd0, mism;
    logic [7:0] rb;
    // R1 reset state
    waitCyc(8);
    chk("R1 drive in reset", int'(sdaDriveLow), 0);
    chk("R1 pointer in reset", int'(regAddr), 0);
    chk("R1 strobes in reset", int'({regWrEn, regRdEn}), 0);
    rstN = 1'b1;
    waitCyc(8);

    // table walk: single-byte writes (R2, R5, R6)
    foreach (WR_VEC[k]) begin
      logic [7:0] p, d;
      {p, d} = WR_VEC[k][16:1];
      w0 = wrCount;
      busStart();
      sendByte(AW0, ack); chk("R2 own address ack", ack, 1);
      sendByte(p, ack);   chk("R5 pointer ack", ack, 1);
      sendByte(d, ack);   chk("R6 data ack vs valid", ack, int'(WR_VEC[k][0]));
      busStop();
      if (WR_VEC[k][0]) expMem[p] = d;
      chk("R6 write count", wrCount - w0, int'(WR_VEC[k][0]));
      chk("R6 pointer stepped", int'(regAddr), int'(8'(p + 1)));
    end

    // burst write crossing the last supported register (R5, R6)
    w0 = wrCount;
    busStart();
    sendByte(AW0, ack);
    sendByte(8'd10, ack);
    sendByte(8'hD0, ack); chk("R6 burst ack reg10", ack, 1);
    sendByte(8'hD1, ack); chk("R6 burst ack reg11", ack, 1);
    sendByte(8'hD2, ack); chk("R6 burst nack reg12", ack, 0);
    busStop();
    expMem[10] = 8'hD0; expMem[11] = 8'hD1;
    chk("R5 burst write count", wrCount - w0, 2);
    chk("R9 pointer kept after STOP", int'(regAddr), 13);
    mism = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== expMem[i]) mism++;
    chk("R5 bank contents", mism, 0);

    // read with repeated START (R7, R8)
    rd0 = rdCount;
    busStart();
    sendByte(AW0, ack);
    sendByte(8'd5, ack);
    busStart();
    sendByte(AR0, ack);   chk("R7 read address ack", ack, 1);
    recvByte(1'b1, rb);   chk("R7 read byte reg5", int'(rb), int'(expMem[5]));
    recvByte(1'b1, rb);   chk("R7 read byte reg6", int'(rb), int'(expMem[6]));
    recvByte(1'b0, rb);   chk("R7 read byte reg7", int'(rb), int'(expMem[7]));
    chk("R8 fetch count", rdCount - rd0, 3);
    recvByte(1'b0, rb);   chk("R8 SDA released after NACK", int'(rb), 8'hFF);
    chk("R8 no fetch after NACK", rdCount - rd0, 3);
    busStop();
    chk("R8 pointer one past last", int'(regAddr), 8);

    // read without pointer byte continues from kept pointer (R9)
    busStart();
    sendByte(AR0, ack);
    recvByte(1'b0, rb);   chk("R9 read from kept pointer", int'(rb), int'(expMem[8]));
    busStop();

    // START in the middle of a data byte aborts (R9)
    w0 = wrCount;
    busStart();
    sendByte(AW0, ack);
    sendByte(8'd0, ack);
    sendBits(8'hEE, 4);
    busStart();
    sendByte(AR0, ack);   chk("R9 address after abort", ack, 1);
    recvByte(1'b0, rb);   chk("R9 reg0 untouched", int'(rb), int'(expMem[0]));
    busStop();
    chk("R9 no write on abort", wrCount - w0, 0);

    // foreign addresses (R3)
    w0 = wrCount;
    busStart();
    sendByte(AW1, ack);   chk("R3 other address nack", ack, 0);
    sendByte(8'h55, ack); chk("R3 following byte ignored", ack, 0);
    busStop();
    busStart();
    sendByte(8'h20, ack); chk("R3 address 0x10 nack", ack, 0);
    busStop();
    chk("R3 no write", wrCount - w0, 0);

    // general call reloads the strap bit (R4)
    addrSel = 1'b1;
    busStart();
    sendByte(8'h00, ack); chk("R4 general call nack", ack, 0);
    busStop();
    busStart();
    sendByte(AW1, ack);   chk("R4 new address ack", ack, 1);
    sendByte(8'd1, ack);
    sendByte(8'h42, ack); chk("R4 write via new address", ack, 1);
    busStop();
    expMem[1] = 8'h42;
    chk("R4 bank reg1", int'(mem[1]), 8'h42);
    busStart();
    sendByte(AW0, ack);   chk("R4 old address nack", ack, 0);
    busStop();

    // reset reloads the strap bit (R1, R2)
    addrSel = 1'b0;
    rstN = 1'b0;
    waitCyc(4);
    chk("R1 pointer after reset", int'(regAddr), 0);
    rstN = 1'b1;
    waitCyc(4);
    busStart();
    sendByte(AW0, ack);   chk("R2 address after reset", ack, 1);
    busStop();
    busStart();
    sendByte(AR1, ack);   chk("R2 other strap nack", ack, 0);
    busStop();

    chk("R10 drive changed with SCL high", r10Viol, 0);
    chk("R11 write and read strobe together", r11Viol, 0);

    done = 1;
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end
endmodule